// File: doc/BRIEF.md
# JTAG Debug DMA Access Sequencer

This block is a JTAG master that carries out one memory read or one memory write on a debug target. The target offers a DMA path behind its TAP. A request port takes an address, an access size (byte, halfword or word), a direction and write data. The block then drives TCK, TMS and TDI, and listens on TDO, to perform the scans the target expects.

Every access follows the same order:

1. Load the address.
2. For a write, load the data word.
3. Issue a control word that starts the transfer.
4. Poll the control register until the target reports the transfer finished.
5. For a read, fetch the data word.
6. Close the access with a final control scan, which also returns the target's error bit.

If that error bit is set, the whole access is replayed a bounded number of times. If the target never finishes within a bounded number of polls, the access ends in error.

Sub-word accesses are handled at both ends. Write data is copied into every lane before it is shifted out. Read data is taken from the lane that the low address bits select, then zero-extended.

The sequencer is a single state machine with these states:

| State | Action |
|---|---|
| `ST_IDLE` | Waits for a request. |
| `ST_ADDR_IR`, `ST_ADDR_DR` | Address instruction, then the address. |
| `ST_WDAT_IR`, `ST_WDAT_DR` | Data instruction, then the write word (writes only). |
| `ST_CTL_IR`, `ST_START_DR` | Control instruction, then the start word. |
| `ST_POLL_DR` | Repeated control scans until the start bit clears. |
| `ST_RDAT_IR`, `ST_RDAT_DR` | Data instruction, then capture of the read word (reads only). |
| `ST_CLR_IR`, `ST_CLR_DR` | Control instruction (reads only), then the closing all-zero control scan. |
| `ST_DONE` | One-cycle result. |

Transitions:

- `ST_IDLE` goes to `ST_ADDR_IR` when a request arrives.
- `ST_ADDR_DR` goes to `ST_WDAT_IR` for a write, or to `ST_CTL_IR` for a read.
- `ST_WDAT_DR` goes to `ST_CTL_IR`.
- `ST_START_DR` goes to `ST_POLL_DR`.
- `ST_POLL_DR` stays in place while the start bit reads back as one.
  - When the start bit reads zero, it goes to `ST_CLR_DR` for a write, or to `ST_RDAT_IR` for a read.
  - When the poll limit is reached, it goes to `ST_DONE` (timeout).
- `ST_RDAT_DR` goes to `ST_CLR_IR`, and `ST_CLR_IR` goes to `ST_CLR_DR`.
- `ST_CLR_DR` goes back to `ST_ADDR_IR` on a retried error, and otherwise to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Every other state moves to its successor in the list once its scan completes.

Top module: `dbg_dma_sequencer`

## Requirements
- R1: After reset `busy`, `done`, `err`, `tck`, `tms` and `tdi` are low and `rdata` is zero.
- R2: A request is taken only in a cycle where `req_valid` is high and `busy` is low. A request presented while `busy` is high has no effect, including in the cycle where `done` is high.
- R3: The instruction register is 5 bits wide. The address instruction is 0x08, the data instruction is 0x09 and the control instruction is 0x0A. No other instruction value is ever loaded, and the TAP is back in Run-Test/Idle after every scan.
- R4: The start control word has bit 17 (DMA enable) set, bit 11 (start) set, bit 9 set for a read only, and bits 8:7 set to the size. The size codes are 00 for byte, 01 for halfword and 10 for word, and a requested size of 11 is handled as word.
- R5: After the start scan, the block rescans control with only bit 17 set, until the captured bit 11 is zero. If POLL_LIMIT polls in a row all capture bit 11 set, the access ends with `err` and no retry.
- R6: After completion (and, for a read, after one data scan), control is scanned with the value zero. If the captured bit 10 is set, the access restarts from the address scan, up to RETRIES times, after which it ends with `err`.
- R7: A halfword read returns bits 31:16 when address bit 1 is set and bits 15:0 otherwise. A byte read returns byte lane addr[1:0], where lane n is bits 8n+7:8n. Both are zero-extended.
- R8: Write data is shifted out with a halfword copied into both halves, or a byte copied into all four lanes. A word is shifted out unchanged.
- R9: `done` is a one-cycle pulse. `err` is high only together with `done`. `rdata` holds the result in the `done` cycle, and `busy` is low in the cycle after `done`.
- R10: TCK has a high phase of TCK_HALF clock cycles. TMS and TDI change only while TCK is low, and TCK stays low whenever no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word (11 = word) |
| req_addr | input | 32 | Target byte address |
| req_wdata | input | 32 | Write value, right-aligned for sub-word sizes |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Access failed, valid with `done` |
| rdata | output | 32 | Read result, valid with `done` |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |

## Verification
The poll step can finish an access in two ways on the same scan: the start bit reads back clear, or the poll limit is exhausted. The bench's target model holds the start bit for exactly POLL_LIMIT-1 polls, which must succeed. It then holds it for POLL_LIMIT polls, which must fail after a single attempt. The retry bound gets the same edge treatment: errors are injected RETRIES and RETRIES+1 times. The bench then judges both `err` and how many start commands reached the target.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    localparam int WORD_W = 32;
    localparam int IRW    = 5;

    localparam logic [IRW-1:0] IR_ADDR = 5'h08;
    localparam logic [IRW-1:0] IR_DATA = 5'h09;
    localparam logic [IRW-1:0] IR_CTRL = 5'h0A;

    localparam int CB_DMA   = 17;
    localparam int CB_START = 11;
    localparam int CB_ERR   = 10;
    localparam int CB_RD    = 9;
    localparam int CB_SZ    = 7;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10
    } xfer_size_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_IR,
        ST_ADDR_DR,
        ST_WDAT_IR,
        ST_WDAT_DR,
        ST_CTL_IR,
        ST_START_DR,
        ST_POLL_DR,
        ST_RDAT_IR,
        ST_RDAT_DR,
        ST_CLR_IR,
        ST_CLR_DR,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/tck_gen.sv
module tck_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tck,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = (cnt == CW'(HALF - 1));
    assign rise = en && wrap && !tck;
    assign fall = en && wrap && tck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            tck <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            tck <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            tck <= ~tck;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine #(
    parameter int W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      is_ir,
    input  logic [$clog2(W+1)-1:0]    len,
    input  logic [W-1:0]              din,
    input  logic                      rise,
    input  logic                      fall,
    input  logic                      tdo,
    output logic                      busy,
    output logic                      done,
    output logic [W-1:0]              dout,
    output logic                      tms,
    output logic                      tdi
);
    localparam int LW = $clog2(W + 1);
    localparam int SW = $clog2(W + 8);

    logic [SW-1:0] k;
    logic [W-1:0]  sr;
    logic          ir_q;
    logic [LW-1:0] len_q;
    logic          shift_now;
    logic          last_step;

    // TMS for step n: lead-in walks Idle -> Shift, last shift bit exits,
    // then Update and back to Run-Test/Idle.
    function automatic logic tms_for(input int n, input logic ir, input int l);
        int pre;
        pre = ir ? 4 : 3;
        if (n < pre)          return (n == 0) || (ir && n == 1);
        else if (n < pre + l) return (n == pre + l - 1);
        else                  return (n == pre + l);
    endfunction

    always_comb begin
        int pre;
        pre       = ir_q ? 4 : 3;
        shift_now = (int'(k) >= pre) && (int'(k) < pre + int'(len_q));
        last_step = (int'(k) == pre + int'(len_q) + 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            k     <= '0;
            sr    <= '0;
            dout  <= '0;
            ir_q  <= 1'b0;
            len_q <= '0;
            tms   <= 1'b0;
            tdi   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    k     <= '0;
                    sr    <= din;
                    ir_q  <= is_ir;
                    len_q <= len;
                    tms   <= 1'b1;
                    tdi   <= 1'b0;
                end
            end else begin
                if (rise && shift_now) begin
                    dout <= {tdo, dout[W-1:1]};
                    sr   <= sr >> 1;
                end
                if (fall) begin
                    if (last_step) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        tms  <= 1'b0;
                        tdi  <= 1'b0;
                    end else begin
                        k   <= k + 1'b1;
                        tms <= tms_for(int'(k) + 1, ir_q, int'(len_q));
                        tdi <= sr[0];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import dmaseq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   wr_size,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] wr_bus,
    input  logic [1:0]   rd_size,
    input  logic [1:0]   rd_off,
    input  logic [W-1:0] rd_word,
    output logic [W-1:0] rd_val
);
    localparam int BYTES = W / 8;
    localparam int HW    = W / 2;

    logic [7:0] lane [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lane[g] = rd_word[8*g +: 8];
    end

    always_comb begin
        unique case (wr_size)
            SZ_BYTE: wr_bus = {BYTES{wr_val[7:0]}};
            SZ_HALF: wr_bus = {2{wr_val[HW-1:0]}};
            default: wr_bus = wr_val;
        endcase
    end

    always_comb begin
        unique case (rd_size)
            SZ_BYTE: rd_val = W'(lane[rd_off]);
            SZ_HALF: rd_val = rd_off[1] ? W'(rd_word[W-1:HW]) : W'(rd_word[HW-1:0]);
            default: rd_val = rd_word;
        endcase
    end
endmodule

// File: rtl/dbg_dma_sequencer.sv
module dbg_dma_sequencer
    import dmaseq_pkg::*;
#(
    parameter int TCK_HALF   = 2,
    parameter int RETRIES    = 3,
    parameter int POLL_LIMIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [31:0] rdata,
    output logic        tck,
    output logic        tms,
    output logic        tdi,
    input  logic        tdo
);
    localparam int LW = $clog2(WORD_W + 1);
    localparam int TW = $clog2(RETRIES + 2);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    seq_state_e state, nxt;

    logic [WORD_W-1:0] addr_q, wbus_q, rword_q, wr_bus, rd_val;
    logic [1:0]        size_q, size_n;
    logic              wr_q, err_q, issued;
    logic [TW-1:0]     tries;
    logic [PW-1:0]     polls;

    logic              scan_start, scan_is_ir, scan_done, eng_busy;
    logic [LW-1:0]     scan_len;
    logic [WORD_W-1:0] scan_din, eng_res;
    logic              rise, fall;

    logic [WORD_W-1:0] start_word, poll_word;

    assign size_n = (req_size == 2'b11) ? SZ_WORD : req_size;

    always_comb begin
        start_word                       = '0;
        start_word[CB_DMA]               = 1'b1;
        start_word[CB_START]             = 1'b1;
        start_word[CB_RD]                = !wr_q;
        start_word[CB_SZ+1:CB_SZ]        = size_q;
        poll_word                        = '0;
        poll_word[CB_DMA]                = 1'b1;
    end

    tck_gen #(.HALF(TCK_HALF)) u_tck (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (eng_busy),
        .tck  (tck),
        .rise (rise),
        .fall (fall)
    );

    jtag_scan_engine #(.W(WORD_W)) u_eng (
        .clk  (clk),
        .rst_n(rst_n),
        .start(scan_start),
        .is_ir(scan_is_ir),
        .len  (scan_len),
        .din  (scan_din),
        .rise (rise),
        .fall (fall),
        .tdo  (tdo),
        .busy (eng_busy),
        .done (scan_done),
        .dout (eng_res),
        .tms  (tms),
        .tdi  (tdi)
    );

    lane_steer #(.W(WORD_W)) u_lane (
        .wr_size(size_n),
        .wr_val (req_wdata),
        .wr_bus (wr_bus),
        .rd_size(size_q),
        .rd_off (addr_q[1:0]),
        .rd_word(rword_q),
        .rd_val (rd_val)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid) nxt = ST_ADDR_IR;
            ST_ADDR_IR:  if (scan_done) nxt = ST_ADDR_DR;
            ST_ADDR_DR:  if (scan_done) nxt = wr_q ? ST_WDAT_IR : ST_CTL_IR;
            ST_WDAT_IR:  if (scan_done) nxt = ST_WDAT_DR;
            ST_WDAT_DR:  if (scan_done) nxt = ST_CTL_IR;
            ST_CTL_IR:   if (scan_done) nxt = ST_START_DR;
            ST_START_DR: if (scan_done) nxt = ST_POLL_DR;
            ST_POLL_DR: begin
                if (scan_done) begin
                    if (!eng_res[CB_START])             nxt = wr_q ? ST_CLR_DR : ST_RDAT_IR;
                    else if (int'(polls) == POLL_LIMIT - 1) nxt = ST_DONE;
                end
            end
            ST_RDAT_IR:  if (scan_done) nxt = ST_RDAT_DR;
            ST_RDAT_DR:  if (scan_done) nxt = ST_CLR_IR;
            ST_CLR_IR:   if (scan_done) nxt = ST_CLR_DR;
            ST_CLR_DR: begin
                if (scan_done) begin
                    if (eng_res[CB_ERR] && int'(tries) < RETRIES) nxt = ST_ADDR_IR;
                    else                                          nxt = ST_DONE;
                end
            end
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Outputs and scan parameters
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_DONE);
        err        = done && err_q;
        rdata      = done ? rd_val : '0;
        scan_is_ir = 1'b0;
        scan_len   = LW'(WORD_W);
        scan_din   = '0;
        unique case (state)
            ST_ADDR_IR:  begin scan_is_ir = 1'b1; scan_len = LW'(IRW); scan_din = WORD_W'(IR_ADDR); end
            ST_WDAT_IR,
            ST_RDAT_IR:  begin scan_is_ir = 1'b1; scan_len = LW'(IRW); scan_din = WORD_W'(IR_DATA); end
            ST_CTL_IR,
            ST_CLR_IR:   begin scan_is_ir = 1'b1; scan_len = LW'(IRW); scan_din = WORD_W'(IR_CTRL); end
            ST_ADDR_DR:  scan_din = addr_q;
            ST_WDAT_DR:  scan_din = wbus_q;
            ST_START_DR: scan_din = start_word;
            ST_POLL_DR:  scan_din = poll_word;
            default:     scan_din = '0;
        endcase
        scan_start = (state != ST_IDLE) && (state != ST_DONE) && !issued && !eng_busy;
    end

    // Access context and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued  <= 1'b0;
            addr_q  <= '0;
            size_q  <= SZ_WORD;
            wr_q    <= 1'b0;
            wbus_q  <= '0;
            rword_q <= '0;
            tries   <= '0;
            polls   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (scan_start)     issued <= 1'b1;
            else if (scan_done) issued <= 1'b0;

            if (state == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                size_q <= size_n;
                wr_q   <= req_write;
                wbus_q <= wr_bus;
                tries  <= '0;
                err_q  <= 1'b0;
            end

            if (scan_done) begin
                unique case (state)
                    ST_START_DR: polls <= '0;
                    ST_POLL_DR: begin
                        if (eng_res[CB_START]) begin
                            polls <= polls + 1'b1;
                            if (int'(polls) == POLL_LIMIT - 1) err_q <= 1'b1;
                        end
                    end
                    ST_RDAT_DR: rword_q <= eng_res;
                    ST_CLR_DR: begin
                        err_q <= eng_res[CB_ERR];
                        if (eng_res[CB_ERR] && int'(tries) < RETRIES) tries <= tries + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_seq_checks.sv
module dma_seq_checks (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic err,
    input logic tck,
    input logic tms,
    input logic tdi
);
    // R2
    accept_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    err_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R9
    release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10
    pins_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> ($stable(tms) && $stable(tdi)));

    // R10
    tck_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);
endmodule

bind dbg_dma_sequencer dma_seq_checks u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .tck      (tck),
    .tms      (tms),
    .tdi      (tdi)
);

// File: tb/dbg_dma_sequencer_test.sv
module dbg_dma_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 1;
    localparam int RETR = 2;
    localparam int PLIM = 4;
    localparam int OP_LIMIT = 20000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic busy, done, err, tck, tms, tdi;
    logic tdo = 1'b0;
    logic [31:0] rdata;

    int checks = 0, fails = 0;
    bit hung = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_dma_sequencer #(.TCK_HALF(HALF), .RETRIES(RETR), .POLL_LIMIT(PLIM)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo));

    // ---------------- target model ----------------
    localparam int TLR=0, RTI=1, SDR=2, CDR=3, SHDR=4, E1DR=5, PDR=6, E2DR=7, UDR=8,
                   SIR=9, CIR=10, SHIR=11, E1IR=12, PIR=13, E2IR=14, UIR=15;
    int tap = RTI;
    logic [4:0]  t_ir = 5'h0, isr = '0;
    logic [31:0] t_addr = '0, t_data = '0, dsr = '0, last_wword = '0;
    logic [31:0] tgt_mem [16];
    logic [31:0] ref_mem [16];
    logic dma_flag = 0, derr = 0, dma_rw = 0;
    logic [1:0] dma_sz = 0;
    int busy_cnt = 0, lat = 0, inj = 0, starts = 0, bad_ir = 0;

    function automatic int tap_next(int s, logic m);
        case (s)
            TLR:  return m ? TLR  : RTI;   RTI:  return m ? SDR  : RTI;
            SDR:  return m ? SIR  : CDR;   CDR:  return m ? E1DR : SHDR;
            SHDR: return m ? E1DR : SHDR;  E1DR: return m ? UDR  : PDR;
            PDR:  return m ? E2DR : PDR;   E2DR: return m ? UDR  : SHDR;
            UDR:  return m ? SDR  : RTI;   SIR:  return m ? TLR  : CIR;
            CIR:  return m ? E1IR : SHIR;  SHIR: return m ? E1IR : SHIR;
            E1IR: return m ? UIR  : PIR;   PIR:  return m ? E2IR : PIR;
            E2IR: return m ? UIR  : SHIR;  default: return m ? SDR : RTI;
        endcase
    endfunction

    task automatic do_op();
        int idx;
        idx = int'(t_addr[5:2]);
        if (inj > 0) begin inj--; derr = 1; end
        else if (dma_rw) t_data = tgt_mem[idx];
        else begin
            for (int b = 0; b < 4; b++) begin
                bit en;
                en = (dma_sz == 2'b10) ? 1'b1 :
                     (dma_sz == 2'b01) ? ((b / 2) == int'(t_addr[1])) : (b == int'(t_addr[1:0]));
                if (en) tgt_mem[idx][8*b +: 8] = t_data[8*b +: 8];
            end
        end
    endtask

    always @(posedge tck) begin
        case (tap)
            CDR: begin
                if (t_ir == 5'h08) dsr = t_addr;
                else if (t_ir == 5'h09) dsr = t_data;
                else if (t_ir == 5'h0A) begin
                    dsr = '0; dsr[17] = dma_flag; dsr[11] = (busy_cnt > 0); dsr[10] = derr;
                    if (busy_cnt > 0) begin busy_cnt--; if (busy_cnt == 0) do_op(); end
                end else dsr = '0;
            end
            SHDR: dsr = {tdi, dsr[31:1]};
            UDR: begin
                if (t_ir == 5'h08) t_addr = dsr;
                else if (t_ir == 5'h09) t_data = dsr;
                else if (t_ir == 5'h0A) begin
                    dma_flag = dsr[17];
                    if (dsr[17] && dsr[11]) begin
                        starts++; derr = 0; dma_rw = dsr[9]; dma_sz = dsr[8:7];
                        busy_cnt = lat;
                        if (!dsr[9]) last_wword = t_data;
                        if (lat == 0) do_op();
                    end
                end
            end
            CIR:  isr = 5'b00001;
            SHIR: isr = {tdi, isr[4:1]};
            UIR: begin
                t_ir = isr;
                if (isr != 5'h08 && isr != 5'h09 && isr != 5'h0A) bad_ir++;
            end
            default: ;
        endcase
        tap = tap_next(tap, tms);
    end

    always @(negedge tck) begin
        if (tap == SHDR) tdo <= dsr[0];
        else if (tap == SHIR) tdo <= isr[0];
    end

    // R10 monitor: high phase length of TCK
    int hi_cnt = 0, tck_bad = 0;
    always @(negedge clk) begin
        if (tck) hi_cnt++;
        else begin
            if (hi_cnt != 0 && hi_cnt != HALF) tck_bad++;
            hi_cnt = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] repl(input logic [1:0] sz, input logic [31:0] v);
        if (sz == 2'b00) return {4{v[7:0]}};
        if (sz == 2'b01) return {2{v[15:0]}};
        return v;
    endfunction

    function automatic logic [31:0] extract(input logic [1:0] sz, input logic [1:0] off, input logic [31:0] w);
        if (sz == 2'b00) return (w >> (8 * off)) & 32'hFF;
        if (sz == 2'b01) return off[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        return w;
    endfunction

    function automatic logic [31:0] merge(input logic [1:0] sz, input logic [1:0] off,
                                          input logic [31:0] old, input logic [31:0] v);
        logic [31:0] r;
        r = old;
        if (sz == 2'b00) r[8*off +: 8] = v[7:0];
        else if (sz == 2'b01) begin
            if (off[1]) r[31:16] = v[15:0]; else r[15:0] = v[15:0];
        end else r = v;
        return r;
    endfunction

    // One access; junk request held while busy and through the done cycle (R2)
    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] wd, output logic e, output logic [31:0] rd,
                          output int nstart);
        int cyc, s0;
        e = 1'b0; rd = '0; nstart = 0;
        if (hung) return;
        s0 = starts;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_write = ~wr; req_size = 2'b00; req_addr = a ^ 32'h0000_0024; req_wdata = 32'hDEAD_BEEF;
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc > OP_LIMIT) begin
                hung = 1; checks++; fails++;
                $display("FAIL R9 watchdog actual=no_done expected=done");
                req_valid = 0;
                return;
            end
        end
        e = err; rd = rdata;
        @(negedge clk);
        check("R9 done pulse width", {31'b0, done}, 32'h0);
        check("R9 busy after done", {31'b0, busy}, 32'h0);
        req_valid = 0;
        repeat (3) @(negedge clk);
        check("R2 junk request ignored", {31'b0, busy}, 32'h0);
        check("R2 address taken at accept", t_addr, a);
        check("R3 TAP in Run-Test/Idle", tap, RTI);
        nstart = starts - s0;
    endtask

    initial begin
        logic e;
        logic [31:0] rd;
        int ns;

        for (int i = 0; i < 16; i++) begin
            tgt_mem[i] = 32'h9E37_79B9 * (i + 1);
            ref_mem[i] = tgt_mem[i];
        end

        repeat (3) @(negedge clk);
        check("R1 busy reset", {31'b0, busy}, 0);
        check("R1 done reset", {31'b0, done}, 0);
        check("R1 err reset", {31'b0, err}, 0);
        check("R1 pins reset", {29'b0, tck, tms, tdi}, 0);
        check("R1 rdata reset", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep sizes and lane offsets: write, sub-word readback, full-word readback
        for (int sz = 0; sz < 3; sz++) begin
            for (int off = 0; off < 4; off++) begin
                int idx;
                logic [31:0] a, v;
                idx = sz * 4 + off;
                a = 32'h1000_0000 + 32'(idx * 4 + off);
                v = {8'(8'h11 * (off + 1)), 8'(8'h23 + sz), 8'(8'h5A ^ off), 8'(8'h30 + sz * 4 + off)};
                lat = (sz + off) % PLIM;
                inj = 0;
                access(1'b1, 2'(sz), a, v, e, rd, ns);
                ref_mem[idx] = merge(2'(sz), 2'(off), ref_mem[idx], v);
                check("R6 write no error", {31'b0, e}, 0);
                check("R5 one start per clean write", ns, 1);
                check("R8 replicated write word", last_wword, repl(2'(sz), v));
                check("R4 size field applied to memory", tgt_mem[idx], ref_mem[idx]);
                access(1'b0, 2'(sz), a, 32'h0, e, rd, ns);
                check("R7 lane extraction", rd, extract(2'(sz), 2'(off), ref_mem[idx]));
                check("R6 read no error", {31'b0, e}, 0);
                lat = 0;
                access(1'b0, 2'b10, a & ~32'h3, 32'h0, e, rd, ns);
                check("R4 neighbour lanes intact", rd, ref_mem[idx]);
            end
        end

        // Size code 11 handled as word
        lat = 1;
        access(1'b0, 2'b11, 32'h1000_0032, 32'h0, e, rd, ns);
        check("R4 size 11 read as word", rd, ref_mem[12]);

        // Retry bound: 0..RETR+1 injected errors on a write
        for (int n = 0; n <= RETR + 1; n++) begin
            logic [31:0] v;
            v = 32'hA500_0000 | 32'(n);
            lat = 1;
            inj = n;
            access(1'b1, 2'b10, 32'h1000_0034, v, e, rd, ns);
            check("R6 error after retries exhausted", {31'b0, e}, (n > RETR) ? 32'h1 : 32'h0);
            check("R6 attempt count", ns, (n > RETR) ? RETR + 1 : n + 1);
            if (n <= RETR) ref_mem[13] = v;
            check("R6 memory only on success", tgt_mem[13], ref_mem[13]);
        end
        inj = 0;

        // Poll bound: last allowed poll completes, one more times out
        lat = PLIM - 1;
        access(1'b0, 2'b10, 32'h1000_0038, 32'h0, e, rd, ns);
        check("R5 completes on final poll", {31'b0, e}, 0);
        check("R5 data on final poll", rd, ref_mem[14]);
        lat = PLIM;
        access(1'b0, 2'b10, 32'h1000_0038, 32'h0, e, rd, ns);
        check("R5 timeout reports error", {31'b0, e}, 1);
        check("R5 timeout not retried", ns, 1);
        lat = 0;
        access(1'b0, 2'b01, 32'h1000_003E, 32'h0, e, rd, ns);
        check("R7 halfword after timeout", rd, extract(2'b01, 2'b10, ref_mem[15]));

        check("R3 only defined instructions", bad_ir, 0);
        check("R10 TCK high phase", tck_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule